// File: doc/BRIEF.md
# Suspend Modulation Controller

This block throttles a processor core by driving an active-low suspend line through alternating phases. While the feature is enabled, the line is released for a programmed number of ticks and then held low for another programmed number of ticks, over and over. The tick input sets the time base. Both phase lengths are stored in registers.

A system management interrupt (SMI) should run at full speed, so an incoming SMI pulse pauses modulation in one of two ways, picked by a configuration bit. In the timed way, a speedup count is loaded into a down-counter and modulation waits until the counter reaches zero. In the latched way, modulation stays paused until software reads the release register. A status register mirrors the enable bit. The SMI handler reads this to decide whether it must perform the release read on exit. A further configuration bit requests a deeper power-down mode and is brought out on a pin.

Top module: `susp_mod_ctrl`

## Requirements
- R1: After reset, the configuration reads 00h, both phase lengths and the speedup count read 0, `susp_n` is high and `pwrdn_mode` is low.
- R2: The register addresses are: 0 configuration, 1 low-phase length, 2 high-phase length, 3 speedup count, 4 status, 5 release. Configuration bit 0 is enable, bit 1 selects latched SMI handling, and bit 2 requests power-down. Configuration bits 7:3 always read 0, and the lengths and the count read back as written.
- R3: When enable goes from 0 to 1, `susp_n` first stays high for the high-phase length in ticks. It then goes low for the low-phase length in ticks, and this repeats.
- R4: A phase length of 0 counts as one tick.
- R5: While enable is 0, `susp_n` stays high and SMI pulses are ignored: no pause is recorded, and bit 0 of a release read is 0.
- R6: With enable = 1 and bit 1 = 0, an SMI raises `susp_n` in the same cycle. The speedup count is loaded, and `susp_n` stays high for that many ticks. Modulation then resumes at the start of the high phase.
- R7: An SMI that arrives during a timed pause reloads the full speedup count.
- R8: With enable = 1 and bit 1 = 1, an SMI holds `susp_n` high for any number of ticks until address 5 is read. That read returns 1 in bit 0, and modulation afterwards resumes at the start of the high phase.
- R9: Bit 15 of the status register always equals the enable bit.
- R10: `pwrdn_mode` follows configuration bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only at address 5) |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| smi_pulse | input | 1 | One-cycle system management interrupt pulse |
| tick | input | 1 | Time-base strobe, one cycle per tick |
| susp_n | output | 1 | Active-low suspend output |
| pwrdn_mode | output | 1 | Power-down mode request |

## Verification
The bench builds the block with DATA_W = 16, DUR_W = 8, SPD_W = 8 and OUT_REG = 0. Because the output path is unregistered, the effect of an SMI can be checked in the very cycle the pulse is taken. With the short phase lengths programmed, several full modulation periods, a pause and its resume fit into a handful of ticks. This includes the zero-length case, where the output toggles on every tick.

// File: rtl/susp_mod_pkg.sv
package susp_mod_pkg;

   localparam int ADDR_W   = 3;
   localparam int CFG_BITS = 3;

   // register addresses
   localparam logic [ADDR_W-1:0] REG_CFG     = 3'd0;
   localparam logic [ADDR_W-1:0] REG_ON_LEN  = 3'd1;
   localparam logic [ADDR_W-1:0] REG_OFF_LEN = 3'd2;
   localparam logic [ADDR_W-1:0] REG_SPD_CNT = 3'd3;
   localparam logic [ADDR_W-1:0] REG_STATUS  = 3'd4;
   localparam logic [ADDR_W-1:0] REG_SPD_REL = 3'd5;

   // PH_RUN: suspend released, PH_SUSP: suspend asserted
   typedef enum logic {PH_RUN = 1'b0, PH_SUSP = 1'b1} phase_e;

   // bit 2 pwrdn, bit 1 latched SMI mode, bit 0 enable
   typedef struct packed {
      logic pwrdn;
      logic lat_mode;
      logic mod_en;
   } cfg_t;

endpackage

// File: rtl/susp_mod_regs.sv
module susp_mod_regs
   import susp_mod_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DUR_W  = 8,
   parameter int SPD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              latch_state,
   output cfg_t              cfg,
   output logic [DUR_W-1:0]  on_len,
   output logic [DUR_W-1:0]  off_len,
   output logic [SPD_W-1:0]  spd_cnt,
   output logic              rel_rd,
   output logic [DATA_W-1:0] rd_data
);

   localparam int STAT_BIT = DATA_W - 1;

   logic unused_wr_hi;
   assign unused_wr_hi = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         on_len  <= '0;
         off_len <= '0;
         spd_cnt <= '0;
      end else if (wr_en) begin
         if (addr == REG_CFG)     cfg     <= cfg_t'(wr_data[CFG_BITS-1:0]);
         if (addr == REG_ON_LEN)  on_len  <= wr_data[DUR_W-1:0];
         if (addr == REG_OFF_LEN) off_len <= wr_data[DUR_W-1:0];
         if (addr == REG_SPD_CNT) spd_cnt <= wr_data[SPD_W-1:0];
      end
   end

   assign rel_rd = rd_en && (addr == REG_SPD_REL);

   always_comb begin
      rd_data = '0;
      if (addr == REG_CFG)     rd_data[CFG_BITS-1:0] = cfg;
      if (addr == REG_ON_LEN)  rd_data[DUR_W-1:0]    = on_len;
      if (addr == REG_OFF_LEN) rd_data[DUR_W-1:0]    = off_len;
      if (addr == REG_SPD_CNT) rd_data[SPD_W-1:0]    = spd_cnt;
      if (addr == REG_STATUS)  rd_data[STAT_BIT]     = cfg.mod_en;
      if (addr == REG_SPD_REL) rd_data[0]            = latch_state;
   end

   // R2: reserved configuration bits never appear on a read
   p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == REG_CFG) |-> (rd_data[7:CFG_BITS] == '0));

   // R2: a written length is visible on the next cycle
   p_len_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_ON_LEN) |=> (on_len == $past(wr_data[DUR_W-1:0])));

endmodule

// File: rtl/susp_mod_speedup.sv
module susp_mod_speedup #(
   parameter int SPD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             lat_mode,
   input  logic             smi,
   input  logic             tick,
   input  logic [SPD_W-1:0] spd_cnt,
   input  logic             rel_rd,
   output logic             latch_q,
   output logic             paused
);

   logic [SPD_W-1:0] timer_q;
   logic             smi_timed;
   logic             smi_latch;

   assign smi_timed = smi && en && !lat_mode;
   assign smi_latch = smi && en && lat_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        timer_q <= '0;
      else if (smi_timed)                timer_q <= spd_cnt;
      else if (tick && timer_q != '0)    timer_q <= timer_q - 1'b1;
   end

   // a new SMI wins over a release read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         latch_q <= 1'b0;
      else if (smi_latch) latch_q <= 1'b1;
      else if (rel_rd)    latch_q <= 1'b0;
   end

   assign paused = latch_q || (timer_q != '0);

   // R7: every timed SMI reloads the full count
   p_timer_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smi_timed |=> (timer_q == $past(spd_cnt)));

   // R6: the timer only moves on a tick or a reload
   p_timer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !smi_timed) |=> $stable(timer_q));

   // R8: the latch is set only by an SMI seen in latched mode
   p_latch_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q) |-> $past(smi && en && lat_mode));

   // R8: a release read without a competing SMI clears the latch
   p_latch_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_rd && !smi_latch) |=> !latch_q);

endmodule

// File: rtl/susp_mod_phase.sv
module susp_mod_phase
   import susp_mod_pkg::*;
#(
   parameter int DUR_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [DUR_W-1:0] on_len,
   input  logic [DUR_W-1:0] off_len,
   output logic             raw_n,
   output logic             susp_n
);

   phase_e           ph_q;
   logic [DUR_W-1:0] cnt_q;
   logic [DUR_W-1:0] dur_sel;
   logic             last;

   assign dur_sel = (ph_q == PH_SUSP) ? on_len : off_len;
   assign last    = (dur_sel == '0) || (cnt_q >= dur_sel - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_RUN;
         cnt_q <= '0;
      end else if (!run) begin
         ph_q  <= PH_RUN;
         cnt_q <= '0;
      end else if (tick) begin
         if (last) begin
            ph_q  <= (ph_q == PH_SUSP) ? PH_RUN : PH_SUSP;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign raw_n = !(run && ph_q == PH_SUSP);

   generate
      if (OUT_REG) begin : g_out_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b1;
            else        out_q <= raw_n;
         end
         assign susp_n = out_q;
      end else begin : g_out_comb
         assign susp_n = raw_n;
      end
   endgenerate

   // R3: the final tick of a phase switches the phase
   p_phase_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && last) |=> (ph_q != $past(ph_q)));

   // R6: after any stop, the restart is in the released phase
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (ph_q == PH_RUN && cnt_q == '0));

endmodule

// File: rtl/susp_mod_ctrl.sv
module susp_mod_ctrl
   import susp_mod_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DUR_W   = 8,
   parameter int SPD_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              smi_pulse,
   input  logic              tick,
   output logic              susp_n,
   output logic              pwrdn_mode
);

   generate
      if (DATA_W < 16) begin : g_bad_data_w
         $error("DATA_W must be at least 16");
      end
      if (DUR_W < 1 || DUR_W > DATA_W) begin : g_bad_dur_w
         $error("DUR_W out of range");
      end
      if (SPD_W < 1 || SPD_W > DATA_W) begin : g_bad_spd_w
         $error("SPD_W out of range");
      end
   endgenerate

   cfg_t             cfg;
   logic [DUR_W-1:0] on_len;
   logic [DUR_W-1:0] off_len;
   logic [SPD_W-1:0] spd_cnt;
   logic             rel_rd;
   logic             latch_q;
   logic             paused;
   logic             run;
   logic             raw_n;

   susp_mod_regs #(.DATA_W(DATA_W), .DUR_W(DUR_W), .SPD_W(SPD_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .latch_state(latch_q),
      .cfg        (cfg),
      .on_len     (on_len),
      .off_len    (off_len),
      .spd_cnt    (spd_cnt),
      .rel_rd     (rel_rd),
      .rd_data    (rd_data)
   );

   susp_mod_speedup #(.SPD_W(SPD_W)) u_speedup (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg.mod_en),
      .lat_mode(cfg.lat_mode),
      .smi     (smi_pulse),
      .tick    (tick),
      .spd_cnt (spd_cnt),
      .rel_rd  (rel_rd),
      .latch_q (latch_q),
      .paused  (paused)
   );

   assign run = cfg.mod_en && !paused;

   susp_mod_phase #(.DUR_W(DUR_W), .OUT_REG(OUT_REG)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .on_len (on_len),
      .off_len(off_len),
      .raw_n  (raw_n),
      .susp_n (susp_n)
   );

   assign pwrdn_mode = cfg.pwrdn;

   // R5: disabled modulation never asserts suspend
   p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.mod_en |-> raw_n);

   // R6: a pending pause keeps suspend released
   p_pause_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> raw_n);

   // R9: status bit 15 tracks the enable bit
   p_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == REG_STATUS) |-> (rd_data[DATA_W-1] == cfg.mod_en));

   // R8: suspend cannot be asserted while the release latch is held
   p_latch_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_q |-> susp_n || OUT_REG);

endmodule

// File: tb/susp_mod_ctrl_bench.sv
module susp_mod_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        smi_pulse = 1'b0;
   logic        tick = 1'b0;
   logic        susp_n;
   logic        pwrdn_mode;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   susp_mod_ctrl #(.DATA_W(16), .DUR_W(8), .SPD_W(8), .OUT_REG(1'b0)) u_susp_mod_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .smi_pulse (smi_pulse),
      .tick      (tick),
      .susp_n    (susp_n),
      .pwrdn_mode(pwrdn_mode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tk();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic smi();
      smi_pulse = 1'b1;
      #1;
      @(negedge clk);
      smi_pulse = 1'b0;
   endtask

   task automatic start_mod(input int d, input int a, input logic [15:0] c);
      wr(3'd0, 16'h0);
      wr(3'd2, 16'(d));
      wr(3'd1, 16'(a));
      wr(3'd0, c);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R1 susp_n", susp_n, 1);
      chk("R1 pwrdn", pwrdn_mode, 0);
      rd(3'd0, v); chk("R1 cfg", v, 0);
      rd(3'd1, v); chk("R1 on_len", v, 0);
      rd(3'd2, v); chk("R1 off_len", v, 0);
      rd(3'd3, v); chk("R1 spd_cnt", v, 0);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      wr(3'd0, 16'h00F8);
      rd(3'd0, v); chk("R2 reserved cfg bits", v, 0);
      wr(3'd1, 16'h00A5); rd(3'd1, v); chk("R2 on_len readback", v, 16'h00A5);
      wr(3'd2, 16'h005A); rd(3'd2, v); chk("R2 off_len readback", v, 16'h005A);
      wr(3'd3, 16'h00C3); rd(3'd3, v); chk("R2 spd readback", v, 16'h00C3);
   endtask

   task automatic t_pwrdn();
      logic [15:0] v;
      wr(3'd0, 16'h0004);
      chk("R10 pwrdn set", pwrdn_mode, 1);
      chk("R10 susp_n idle", susp_n, 1);
      wr(3'd0, 16'h00FC);
      rd(3'd0, v); chk("R2 cfg masked", v, 16'h0004);
      wr(3'd0, 16'h0000);
      chk("R10 pwrdn clear", pwrdn_mode, 0);
   endtask

   task automatic t_pattern(input int d, input int a, input int n, input string req);
      int de = (d == 0) ? 1 : d;
      int ae = (a == 0) ? 1 : a;
      start_mod(d, a, 16'h0001);
      chk({req, " start released"}, susp_n, 1);
      for (int k = 1; k <= n; k++) begin
         tk();
         chk(req, susp_n, ((k % (de + ae)) >= de) ? 0 : 1);
      end
   endtask

   task automatic t_disabled();
      logic [15:0] v;
      start_mod(2, 2, 16'h0002);
      smi();
      rd(3'd5, v); chk("R5 no latch when disabled", v[0], 0);
      for (int k = 0; k < 4; k++) begin
         tk(); chk("R5 held high", susp_n, 1);
      end
      rd(3'd4, v); chk("R9 status off", v[15], 0);
      wr(3'd0, 16'h0001);
      rd(3'd4, v); chk("R9 status on", v[15], 1);
   endtask

   task automatic t_timed();
      wr(3'd3, 16'd3);
      start_mod(2, 2, 16'h0001);
      tk(); tk();
      chk("R3 asserted before SMI", susp_n, 0);
      smi();
      chk("R6 SMI releases", susp_n, 1);
      for (int k = 0; k < 3; k++) begin
         tk(); chk("R6 timed pause", susp_n, 1);
      end
      tk(); chk("R6 resume released phase", susp_n, 1);
      tk(); chk("R6 resume then asserts", susp_n, 0);
   endtask

   task automatic t_reload();
      // continues from t_timed: asserted phase, count 3
      smi();
      tk(); tk();
      smi();
      chk("R7 reload SMI", susp_n, 1);
      tk(); chk("R7 still paused 1", susp_n, 1);
      tk(); chk("R7 still paused 2", susp_n, 1);
      tk(); chk("R7 still paused 3", susp_n, 1);
      tk(); chk("R7 resume released", susp_n, 1);
      tk(); chk("R7 resume asserts", susp_n, 0);
   endtask

   task automatic t_latched();
      logic [15:0] v;
      start_mod(2, 2, 16'h0003);
      tk(); tk();
      chk("R8 asserted before SMI", susp_n, 0);
      smi();
      chk("R8 SMI releases", susp_n, 1);
      for (int k = 0; k < 8; k++) begin
         tk(); chk("R8 latched pause", susp_n, 1);
      end
      rd(3'd4, v); chk("R9 status during latch", v[15], 1);
      rd(3'd5, v); chk("R8 release read bit0", v[0], 1);
      tk(); chk("R8 resume released", susp_n, 1);
      tk(); chk("R8 resume asserts", susp_n, 0);
      rd(3'd5, v); chk("R8 latch cleared", v[0], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_pwrdn();
      t_pattern(3, 2, 12, "R3 phase 3/2");
      t_pattern(1, 4, 11, "R3 phase 1/4");
      t_pattern(0, 0, 6, "R4 zero lengths");
      t_pattern(0, 3, 8, "R4 zero high phase");
      t_disabled();
      t_timed();
      t_reload();
      t_latched();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         nbad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule